// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Interface

This block is the digital front end of a two-channel digital-to-analog converter. A host shifts 24-bit command words in over a three-wire serial port: an active-low frame select, a serial clock and a data line. Each word writes one of two staging buffers and may carry a load flag for each channel. A buffer holds a 16-bit code and a 2-bit power mode. A load copies a buffer into that channel's output register. The output registers drive the per-channel code and mode outputs that the analog section consumes.

The serial pins are brought into the system clock domain through synchronizer chains. The block samples data on each falling serial clock edge and counts those edges. When the count reaches 24, it acts on the whole word in one step. Power-down commands follow the same buffer-then-load path as data. Because the load flags are independent of the buffer select, a single word can write one buffer and update both channels on the same cycle. Channels can also be updated one after another.

Top module: `dac2_cmd_if`

## Requirements
- R1: After reset, both channels output code 0 and mode 00.
- R2: A frame is 24 bits, sampled most significant bit first on falling serial clock edges while frame select is low. Bit positions from the top are: bits 23:22 ignored, bit 21 loads channel B, bit 20 loads channel A, bit 19 ignored, bit 18 selects the buffer (0 = A, 1 = B), bits 17:16 give the mode, bits 15:0 give the code.
- R3: A frame with neither load flag set leaves every output unchanged. The written buffer is still updated and appears at the outputs on a later load.
- R4: A load copies the buffer, including any write made in the same frame, into that channel's output register. With both flags set, both channels update on the same clock cycle.
- R5: The mode encoding is 00 normal, 01 1 kΩ pull-down, 10 100 kΩ pull-down and 11 high impedance. A write with a nonzero mode stores the mode and leaves the buffer's code unchanged, ignoring bits 15:0.
- R6: If frame select rises before the 24th falling edge, no buffer or output changes. The next low period starts a fresh count.
- R7: Falling edges after the 24th, while frame select stays low, are ignored until frame select goes high and then low again.
- R8: Bits 23:22 and bit 19 have no effect on any output.
- R9: Writing buffer A with its load flag, then buffer B with its load flag, updates channel A after the first frame and channel B only after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_n | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| a_code | output | 16 | Channel A output register code |
| a_mode | output | 2 | Channel A power mode |
| b_code | output | 16 | Channel B output register code |
| b_mode | output | 2 | Channel B power mode |

## Verification
A wrong bit count or a wrong field position shows up at the outputs within a few system clocks of the frame's final falling edge. An off-by-one count makes a short frame commit, or makes a full frame fail to commit. A shifted field gives the wrong channel, code or mode. A corrupted staging buffer stays hidden until the next load. For that reason the sweep writes buffers without loading them, then loads them later, sometimes through the other channel's frame. A power-down write that clobbers the stored code is caught only when a later frame loads that buffer. Those checks compare the code output with the value written before the power-down.

// File: rtl/dac2_pkg.sv
// Package dac2_pkg
// Shared types for the dual-channel converter command interface: the power
// mode encoding and the layout of the eight control bits above the code.
package dac2_pkg;

    // Per-channel power mode as carried in the two mode bits of a frame.
    typedef enum logic [1:0] {
        PD_NONE = 2'b00,
        PD_1K   = 2'b01,
        PD_100K = 2'b10,
        PD_HIZ  = 2'b11
    } pd_mode_e;

    localparam int CTRL_W = 8;

    // Control byte, most significant bit first, as it sits above the code.
    typedef struct packed {
        logic [1:0] rsvd;
        logic       ld_b;
        logic       ld_a;
        logic       spare;
        logic       sel_b;
        pd_mode_e   mode;
    } ctrl_t;

endpackage

// File: rtl/dac2_serial_rx.sv
// Module dac2_serial_rx
// Brings the three serial pins into the clk domain, shifts in one bit per
// falling serial clock edge while frame select is low and raises frame_vld
// for one cycle when the FRAME_W-th bit arrives. Frame select high clears
// the count, which aborts a partial frame. Bits after a full frame are
// ignored until frame select has been high.
// Assumes: the serial clock half period spans several clk cycles, and the
// data pin is stable around each falling serial clock edge.
module dac2_serial_rx #(
    parameter int FRAME_W     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               csn_i,
    input  logic               sdi_i,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [SYNC_STAGES-1:0] sclk_sr, csn_sr, sdi_sr;
    logic                   sclk_prev;
    logic                   sclk_s, csn_s, sdi_s, sclk_fall;
    logic [CNT_W-1:0]       cnt;
    logic [FRAME_W-1:0]     shreg;

    // Synchronizer chains; idle levels are loaded on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr   <= '1;
            csn_sr    <= '1;
            sdi_sr    <= '0;
            sclk_prev <= 1'b1;
        end else begin
            sclk_sr   <= {sclk_sr[SYNC_STAGES-2:0], sclk_i};
            csn_sr    <= {csn_sr[SYNC_STAGES-2:0], csn_i};
            sdi_sr    <= {sdi_sr[SYNC_STAGES-2:0], sdi_i};
            sclk_prev <= sclk_sr[SYNC_STAGES-1];
        end
    end

    assign sclk_s    = sclk_sr[SYNC_STAGES-1];
    assign csn_s     = csn_sr[SYNC_STAGES-1];
    assign sdi_s     = sdi_sr[SYNC_STAGES-1];
    assign sclk_fall = sclk_prev & ~sclk_s;

    // Bit counter and shift register; the pulse fires on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
        end else begin
            frame_vld <= 1'b0;
            if (csn_s) begin
                cnt <= '0;
            end else if (sclk_fall && cnt < FULL) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                cnt   <= cnt + 1'b1;
                if (cnt == LAST) begin
                    frame_vld <= 1'b1;
                end
            end
        end
    end

    assign frame_word = shreg;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
    p_abort_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (cnt == '0 && !frame_vld));
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FULL) |=> ($stable(shreg) && !frame_vld));

endmodule

// File: rtl/dac2_chan.sv
// Module dac2_chan
// One double-buffered channel. A write sets the buffer mode and, only for
// normal mode, the buffer code. A load copies the buffer, including a write
// made in the same cycle, into the output register.
// Assumes: wr_en and ld_en are single-cycle frame strobes.
module dac2_chan
    import dac2_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  pd_mode_e          wr_mode,
    input  logic [DATA_W-1:0] wr_code,
    input  logic              ld_en,
    output logic [DATA_W-1:0] dac_code,
    output pd_mode_e          dac_mode
);
    logic [DATA_W-1:0] buf_code, buf_code_n;
    pd_mode_e          buf_mode, buf_mode_n;

    // Next buffer contents after this cycle's write, if any.
    always_comb begin
        buf_mode_n = wr_en ? wr_mode : buf_mode;
        buf_code_n = (wr_en && wr_mode == PD_NONE) ? wr_code : buf_code;
    end

    // Buffer and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_code <= '0;
            buf_mode <= PD_NONE;
            dac_code <= '0;
            dac_mode <= PD_NONE;
        end else begin
            buf_code <= buf_code_n;
            buf_mode <= buf_mode_n;
            if (ld_en) begin
                dac_code <= buf_code_n;
                dac_mode <= buf_mode_n;
            end
        end
    end

    p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> ($stable(dac_code) && $stable(dac_mode)));
    p_code_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mode != PD_NONE) |=> $stable(buf_code));
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (dac_code == buf_code && dac_mode == buf_mode));

endmodule

// File: rtl/dac2_cmd_if.sv
// Module dac2_cmd_if
// Top of the dual-channel command interface. It receives a frame, splits
// off the control byte, and steers the write and the per-channel loads to
// two channel instances.
// Assumes: the pins are asynchronous to clk and resynchronized inside.
module dac2_cmd_if
    import dac2_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [DATA_W-1:0] a_code,
    output logic [1:0]        a_mode,
    output logic [DATA_W-1:0] b_code,
    output logic [1:0]        b_mode
);
    localparam int FRAME_W = DATA_W + CTRL_W;
    localparam int N_CH    = 2;

    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;
    ctrl_t              ctrl;
    logic [DATA_W-1:0]  code_q [N_CH];
    pd_mode_e           mode_q [N_CH];

    dac2_serial_rx #(
        .FRAME_W    (FRAME_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .csn_i     (sync_n),
        .sdi_i     (sdin),
        .frame_vld (frame_vld),
        .frame_word(frame_word)
    );

    assign ctrl = ctrl_t'(frame_word[FRAME_W-1 -: CTRL_W]);

    // One channel per index; index 0 is A, index 1 is B.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic wr_sel, ld_sel;
        assign wr_sel = frame_vld && (ctrl.sel_b == 1'(ch));
        assign ld_sel = frame_vld && ((ch == 0) ? ctrl.ld_a : ctrl.ld_b);

        dac2_chan #(.DATA_W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel),
            .wr_mode (ctrl.mode),
            .wr_code (frame_word[DATA_W-1:0]),
            .ld_en   (ld_sel),
            .dac_code(code_q[ch]),
            .dac_mode(mode_q[ch])
        );
    end

    assign a_code = code_q[0];
    assign a_mode = mode_q[0];
    assign b_code = code_q[1];
    assign b_mode = mode_q[1];

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(a_code) && $stable(a_mode)
                        && $stable(b_code) && $stable(b_mode)));
    p_b_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !ctrl.ld_a) |=> ($stable(a_code) && $stable(a_mode)));

endmodule

// File: tb/tb_dac2_cmd_if.sv
// Bench for dac2_cmd_if. It keeps its own model of both buffers and both
// output registers, computed from the requirements, and compares all four
// outputs after every frame.
module tb_dac2_cmd_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic [15:0] a_code, b_code;
    logic [1:0]  a_mode, b_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_bcode [2];
    logic [1:0]  m_bmode [2];
    logic [15:0] m_dcode [2];
    logic [1:0]  m_dmode [2];

    always #2 clk = ~clk;

    dac2_cmd_if dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .a_code(a_code), .a_mode(a_mode), .b_code(b_code), .b_mode(b_mode)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "a_code", a_code, m_dcode[0]);
        chk(tag, "a_mode", {14'd0, a_mode}, {14'd0, m_dmode[0]});
        chk(tag, "b_code", b_code, m_dcode[1]);
        chk(tag, "b_mode", {14'd0, b_mode}, {14'd0, m_dmode[1]});
    endtask

    // Requirement model of one completed frame.
    task automatic model(input logic [23:0] w);
        int s;
        s = int'(w[18]);
        m_bmode[s] = w[17:16];
        if (w[17:16] == 2'b00) m_bcode[s] = w[15:0];
        if (w[20]) begin m_dcode[0] = m_bcode[0]; m_dmode[0] = m_bmode[0]; end
        if (w[21]) begin m_dcode[1] = m_bcode[1]; m_dmode[1] = m_bmode[1]; end
    endtask

    task automatic bit_out(input logic b);
        sclk = 1'b1; sdin = b;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Shift nbits of w from the top, then nextra bits of extra, then end.
    task automatic send(input logic [23:0] w, input int nbits,
                        input logic [7:0] extra, input int nextra);
        sync_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) bit_out(w[23-i]);
        for (int i = 0; i < nextra; i++) bit_out(extra[7-i]);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sync_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic frame(input logic [23:0] w, input string tag);
        send(w, 24, 8'h00, 0);
        model(w);
        check_all(tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_bcode[c] = '0; m_bmode[c] = '0; m_dcode[c] = '0; m_dmode[c] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R1");

        // Sweep all load/select/mode combinations with several codes (R2-R5).
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c < 32; c++) begin
                logic [23:0] w;
                logic [4:0]  cb;
                string       tag;
                cb = 5'(c);
                w[23:22] = 2'(k);
                w[21]    = cb[4];
                w[20]    = cb[3];
                w[19]    = cb[0] ^ k[0];
                w[18]    = cb[2];
                w[17:16] = cb[1:0];
                w[15:0]  = 16'(c * 2473 + k * 40503 + 1);
                if (!cb[4] && !cb[3]) tag = "R3";
                else if (cb[4] && cb[3]) tag = "R4";
                else if (cb[1:0] != 2'b00) tag = "R5";
                else tag = "R2";
                frame(w, tag);
            end
        end

        // R5: power-down keeps the code, and normal mode then restores it.
        frame({2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 16'hA5C3}, "R5");
        frame({2'b00, 2'b01, 1'b0, 1'b0, 2'b11, 16'h1234}, "R5");
        chk("R5", "a_code held", a_code, 16'hA5C3);
        frame({2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 16'hA5C3}, "R5");

        // R8: ignored bits set; the outputs must match the model.
        frame({2'b11, 2'b11, 1'b1, 1'b1, 2'b00, 16'h0F0F}, "R8");

        // R9: update A, then B.
        frame({2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 16'h1111}, "R9");
        chk("R9", "b not yet", b_code, 16'h0F0F);
        frame({2'b00, 2'b10, 1'b0, 1'b1, 2'b00, 16'h2222}, "R9");
        chk("R9", "b after", b_code, 16'h2222);

        // R6: an aborted frame changes nothing; a full frame follows.
        send({2'b00, 2'b11, 1'b0, 1'b0, 2'b10, 16'hDEAD}, 23, 8'h00, 0);
        check_all("R6");
        frame({2'b00, 2'b11, 1'b0, 1'b1, 2'b00, 16'h3C3C}, "R6");

        // R7: extra edges after the 24th are ignored.
        send({2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 16'h7777}, 24, 8'hFF, 8);
        model({2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 16'h7777});
        check_all("R7");
        frame({2'b00, 2'b10, 1'b0, 1'b1, 2'b01, 16'h0000}, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule